// File: doc/BRIEF.md
# MDIO Station-Management Master

This block is the management master of a PHY management bus. It produces the MDC clock and drives or releases the MDIO line. A PHY register can then be reached with either the classic 22-style frame or the extended 45-style frame, and a mode setting picks which one is used. Three things are held in registers: a settings register (frame style, preamble enable, MDC divider), a payload word, and the result of the last read.

A pulse on the command inputs launches exactly one serial frame. The command carries a 2-bit operation, a 5-bit PHY address and a 5-bit field. That field names the register in the 22-style frame and the managed device number in the 45-style frame. While the frame is on the wire, a flag shows it is in progress. Write-type frames raise the write flag and reads raise the read flag. When a read ends, its 16 captured bits are presented together with a validity bit. A 45-style access is two frames: an address frame whose payload is the register location, then a data frame to the same PHY and device.

Top module: `mdio_master`

## Requirements
- R1: After reset, mdc, mdio_oe, wr_pending, rd_pending and rd_valid are low and rd_data is zero. The settings register resets to 22-style frames, preamble on and a divider of DIV_INIT (default 2).
- R2: A command pulse taken while idle makes the frame a read when the read bit is set: op bit 0 in 22-style, op bit 1 in 45-style. A read raises rd_pending; any other frame raises wr_pending. At most one flag is high at a time, and it stays high for exactly 2·N·(div+1) clock cycles, where N is the number of MDC periods in the frame.
- R3: MDC is low while idle. During a frame MDC toggles every div+1 clock cycles, starting low. MDIO changes only on a falling MDC edge (or at launch), and read bits are sampled on the rising MDC edge.
- R4: With preamble enabled, 32 ones precede the frame and N is 64. With preamble disabled, N is 32.
- R5: A 22-style frame sends start 01, then opcode 10 for a read or 01 for a write, with op bit 1 ignored. It then sends the 5-bit PHY address and the 5-bit register number, MSB first.
- R6: A 45-style frame sends start 00, then the 2-bit op unchanged (00 address, 01 write, 10 read with increment, 11 read). It then sends the PHY address and the 5-bit device number, MSB first.
- R7: On write and address frames the master drives turnaround 1,0 and then the 16-bit payload word, MSB first.
- R8: On reads the master releases MDIO (mdio_oe low) from the first turnaround bit to the end of the frame and shifts in 16 bits MSB first. When rd_pending falls, rd_data holds them, and rd_valid is set only if the second turnaround bit was sampled low.
- R9: A command pulse while either flag is high is ignored. This includes the cycle in which the frame finishes.
- R10: A settings write while a frame is in progress is ignored. Both the running frame and later frames keep the previous settings.
- R11: A write or address frame leaves rd_data and rd_valid unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Settings register write strobe |
| cfg_c45 | input | 1 | 1 selects 45-style frames, 0 selects 22-style |
| cfg_pre | input | 1 | Preamble enable |
| cfg_div | input | DIV_W | MDC half period minus one, in clock cycles |
| wdat_wr | input | 1 | Payload register write strobe |
| wdat | input | 16 | Payload word for write and address frames |
| cmd_wr | input | 1 | Command strobe, launches a frame |
| cmd_op | input | 2 | Operation code |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register number (22-style) or device number (45-style) |
| wr_pending | output | 1 | Write or address frame in progress |
| rd_pending | output | 1 | Read frame in progress |
| rd_valid | output | 1 | Last read was answered by the PHY |
| rd_data | output | 16 | Data of the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
Two functions can fall in the same clock edge: completion of a frame, which clears its flag, and acceptance of a new command. The bench times a command pulse so that it is sampled exactly on the edge where the flag falls. It then judges that no new frame was launched: the flag must drop after the computed frame length and stay low. Settings writes and commands injected mid-frame are judged the same way, by the frame length and by the bits seen on the wire.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W    = 8,
  parameter int DIV_INIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_c45,
  input  logic             cfg_pre,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             wdat_wr,
  input  logic [15:0]      wdat,
  input  logic             cmd_wr,
  input  logic [1:0]       cmd_op,
  input  logic [4:0]       cmd_phy,
  input  logic [4:0]       cmd_reg,
  output logic             wr_pending,
  output logic             rd_pending,
  output logic             rd_valid,
  output logic [15:0]      rd_data,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);

  localparam int FRAME_W = 32;
  localparam int PRE_W   = 32;
  localparam int IDX_W   = $clog2(FRAME_W + PRE_W);
  localparam int POS_W   = $clog2(FRAME_W);

  logic             c45_q, pre_q;
  logic [DIV_W-1:0] div_q, cnt;
  logic [15:0]      wdat_q;
  logic [FRAME_W-1:0] sreg;
  logic [IDX_W-1:0] idx;
  logic             rd_q, ta_ok, mdc_q;

  logic busy, go, rd_cmd, tick, rise, fall, last, in_frame, rel;
  logic [POS_W-1:0] fpos;
  logic [1:0] st_bits, op_bits;

  assign busy     = wr_pending | rd_pending;
  assign go       = cmd_wr & ~busy;
  assign rd_cmd   = c45_q ? cmd_op[1] : cmd_op[0];
  assign st_bits  = c45_q ? 2'b00 : 2'b01;
  assign op_bits  = c45_q ? cmd_op : (rd_cmd ? 2'b10 : 2'b01);
  assign tick     = busy && (cnt == div_q);
  assign rise     = tick & ~mdc_q;
  assign fall     = tick & mdc_q;
  assign last     = (idx == {IDX_W{1'b1}});
  assign in_frame = idx[IDX_W-1];
  assign fpos     = idx[POS_W-1:0];
  assign rel      = rd_q & in_frame & (fpos >= POS_W'(14));

  assign mdc     = mdc_q;
  assign mdio_o  = busy & (in_frame ? sreg[FRAME_W-1] : 1'b1);
  assign mdio_oe = busy & ~rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c45_q  <= 1'b0;
      pre_q  <= 1'b1;
      div_q  <= DIV_W'(DIV_INIT);
      wdat_q <= '0;
    end else begin
      if (cfg_wr && !busy) begin
        c45_q <= cfg_c45;
        pre_q <= cfg_pre;
        div_q <= cfg_div;
      end
      if (wdat_wr) wdat_q <= wdat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pending <= 1'b0;
      rd_pending <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      mdc_q      <= 1'b0;
      cnt        <= '0;
      idx        <= '0;
      sreg       <= '0;
      rd_q       <= 1'b0;
      ta_ok      <= 1'b0;
    end else if (go) begin
      cnt        <= '0;
      mdc_q      <= 1'b0;
      idx        <= pre_q ? '0 : IDX_W'(PRE_W);
      sreg       <= {st_bits, op_bits, cmd_phy, cmd_reg, 2'b10, wdat_q};
      rd_q       <= rd_cmd;
      rd_pending <= rd_cmd;
      wr_pending <= ~rd_cmd;
      ta_ok      <= 1'b0;
      if (rd_cmd) rd_valid <= 1'b0;
    end else if (busy) begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick) mdc_q <= ~mdc_q;
      if (rise && rd_q && in_frame) begin
        if (fpos == POS_W'(15)) ta_ok <= ~mdio_i;
        if (fpos[POS_W-1]) rd_data <= {rd_data[14:0], mdio_i};
      end
      if (fall) begin
        if (last) begin
          wr_pending <= 1'b0;
          rd_pending <= 1'b0;
          if (rd_q) rd_valid <= ta_ok;
        end else begin
          idx <= idx + 1'b1;
          if (in_frame) sreg <= {sreg[FRAME_W-2:0], 1'b0};
        end
      end
    end
  end

  // R2
  pend_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_pending, rd_pending}));

  // R3
  mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R3
  mdio_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));

  // R9
  cmd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> (!$rose(rd_pending) && !$rose(wr_pending)));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(div_q) && $stable(c45_q) && $stable(pre_q)));

  // R8
  valid_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $fell(rd_pending));

endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       cfg_wr = 0, cfg_c45 = 0, cfg_pre = 0;
  logic [7:0] cfg_div = 0;
  logic       wdat_wr = 0;
  logic [15:0] wdat_i = 0;
  logic       cmd_wr = 0;
  logic [1:0] cmd_op = 0;
  logic [4:0] cmd_phy = 0, cmd_reg = 0;
  logic       wr_pending, rd_pending, rd_valid, mdc, mdio_o, mdio_oe, mdio_i;
  logic [15:0] rd_data;

  mdio_master dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_c45(cfg_c45), .cfg_pre(cfg_pre), .cfg_div(cfg_div),
    .wdat_wr(wdat_wr), .wdat(wdat_i),
    .cmd_wr(cmd_wr), .cmd_op(cmd_op), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
    .wr_pending(wr_pending), .rd_pending(rd_pending), .rd_valid(rd_valid),
    .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  int n_chk = 0, n_bad = 0;
  bit cur_c45 = 0, cur_pre = 1;
  int cur_div = 2;

  int rises = 0, base = 0;
  logic prev_mdc = 0;
  logic [63:0] obs_o = '0, obs_oe = '0, phy_vec = '1;

  assign mdio_i = phy_vec[6'(rises - base)];

  always @(negedge clk) begin
    int k;
    if (mdc && !prev_mdc) begin
      k = rises - base;
      if (k >= 0 && k < 64) begin
        obs_o[k]  = mdio_o;
        obs_oe[k] = mdio_oe;
      end
      rises++;
    end
    prev_mdc = mdc;
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_frame(bit c45, bit [1:0] op, bit [4:0] phy,
                                            bit [4:0] rg, bit [15:0] d);
    bit rd;
    bit [1:0] st, ow;
    rd = c45 ? op[1] : op[0];
    st = c45 ? 2'b00 : 2'b01;
    ow = c45 ? op : (rd ? 2'b10 : 2'b01);
    return {st, ow, phy, rg, 2'b10, d};
  endfunction

  task automatic set_cfg(bit c45, bit pre, int div);
    @(negedge clk);
    cfg_wr = 1; cfg_c45 = c45; cfg_pre = pre; cfg_div = 8'(div);
    @(negedge clk);
    cfg_wr = 0;
    cur_c45 = c45; cur_pre = pre; cur_div = div;
  endtask

  // mode: 0 plain, 1 command mid-frame, 2 settings write mid-frame, 3 command on finishing edge
  task automatic run_txn(bit [1:0] op, bit [4:0] phy, bit [4:0] rg, bit [15:0] wd,
                         bit [15:0] rdv, bit ta_good, int mode);
    bit rd;
    int nb, off, L, cyc;
    logic [31:0] fr;
    logic [63:0] ew, ed, m, pm;
    logic [15:0] old_d;
    logic old_v;
    rd  = cur_c45 ? op[1] : op[0];
    nb  = cur_pre ? 64 : 32;
    off = cur_pre ? 32 : 0;
    L   = 2 * nb * (cur_div + 1);
    fr  = exp_frame(cur_c45, op, phy, rg, wd);
    ew = '0; ed = '0; phy_vec = '1;
    m  = (nb == 64) ? '1 : ((64'h1 << nb) - 1);
    pm = cur_pre ? 64'hFFFF_FFFF : 64'h0;
    for (int k = 0; k < nb; k++) begin
      int f;
      if (k < off) begin
        ew[k] = 1'b1; ed[k] = 1'b1;
      end else begin
        f = k - off;
        ew[k] = fr[31-f];
        ed[k] = !(rd && f >= 14);
        if (rd && f == 15) phy_vec[k] = ~ta_good;
        else if (rd && f >= 16) phy_vec[k] = rdv[31-f];
      end
    end
    @(negedge clk);
    wdat_wr = 1; wdat_i = wd;
    @(negedge clk);
    wdat_wr = 0;
    old_d = rd_data; old_v = rd_valid;
    base = rises;
    cmd_wr = 1; cmd_op = op; cmd_phy = phy; cmd_reg = rg;
    @(negedge clk);
    cmd_wr = 0;
    chk(rd_pending == rd && wr_pending == !rd, "R2 flag kind",
        {rd_pending, wr_pending}, {rd, !rd});
    cyc = 1;
    while (1) begin
      if (mode == 1 && cyc == 3) begin
        cmd_wr = 1; cmd_phy = ~phy;
        cmd_op = cur_c45 ? {~rd, 1'b0} : {1'b0, ~rd};
      end
      if (mode == 3 && cyc == L) begin
        cmd_wr = 1; cmd_op = op; cmd_phy = phy;
      end
      if (mode == 2 && cyc == 3) begin
        cfg_wr = 1; cfg_div = 8'(cur_div + 3); cfg_c45 = ~cur_c45; cfg_pre = ~cur_pre;
      end
      @(negedge clk);
      cmd_wr = 0; cfg_wr = 0;
      if (!(wr_pending || rd_pending) || cyc > 20000) break;
      cyc++;
    end
    chk(cyc == L, "R2 R3 R9 R10 frame length", cyc, L);
    chk(rises - base == nb, "R4 MDC period count", rises - base, nb);
    chk(((obs_o ^ ew) & pm) == 0, "R4 preamble ones", obs_o & pm, ew & pm);
    chk(((obs_o ^ ew) & ed & m & ~pm) == 0,
        cur_c45 ? "R6 R7 wire bits" : "R5 R7 wire bits", obs_o & ed & m, ew & ed & m);
    chk(((obs_oe ^ ed) & m) == 0, "R8 drive enable", obs_oe & m, ed & m);
    if (rd) begin
      chk(rd_valid == ta_good, "R8 valid flag", rd_valid, ta_good);
      if (ta_good) chk(rd_data == rdv, "R8 read data", rd_data, rdv);
    end else begin
      chk(rd_data == old_d && rd_valid == old_v, "R11 read result kept",
          {rd_valid, rd_data}, {old_v, old_d});
    end
    repeat (3) @(negedge clk);
    chk(!wr_pending && !rd_pending, "R9 idle after frame",
        {rd_pending, wr_pending}, 0);
    chk(!mdc && !mdio_oe, "R3 MDC low when idle", {mdc, mdio_oe}, 0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #900us;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd77));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!mdc && !mdio_oe && !wr_pending && !rd_pending && !rd_valid && rd_data == 0,
        "R1 reset state", {mdc, mdio_oe, wr_pending, rd_pending, rd_valid, rd_data}, 0);
    // R1: first frame runs on the reset settings (22-style, preamble on, divider 2)
    run_txn(2'b00, 5'h15, 5'h02, 16'h1234, 16'h0, 1, 0);

    set_cfg(0, 0, 0);
    run_txn(2'b00, 5'h1B, 5'h04, 16'hA5C3, 16'h0, 1, 0);
    set_cfg(0, 1, 1);
    run_txn(2'b01, 5'h03, 5'h11, 16'h0, 16'h9E27, 1, 0);
    // R5: op bit 1 ignored in 22-style
    run_txn(2'b11, 5'h0C, 5'h1F, 16'h0, 16'h8001, 1, 0);
    run_txn(2'b10, 5'h00, 5'h00, 16'hFFFF, 16'h0, 1, 0);

    set_cfg(1, 0, 0);
    run_txn(2'b00, 5'h07, 5'h01, 16'hC0DE, 16'h0, 1, 0);
    run_txn(2'b01, 5'h07, 5'h01, 16'h5A5A, 16'h0, 1, 0);
    run_txn(2'b10, 5'h07, 5'h01, 16'h0, 16'h7FFE, 1, 0);
    run_txn(2'b11, 5'h07, 5'h1E, 16'h0, 16'h0F0F, 1, 0);

    // R8: PHY does not answer
    set_cfg(1, 1, 0);
    run_txn(2'b11, 5'h1F, 5'h03, 16'h0, 16'hBEEF, 0, 0);
    run_txn(2'b01, 5'h1F, 5'h03, 16'h2222, 16'h0, 1, 0);

    set_cfg(0, 0, 1);
    run_txn(2'b00, 5'h09, 5'h0A, 16'h3C3C, 16'h0, 1, 1);    // R9 mid-frame
    run_txn(2'b01, 5'h09, 5'h0A, 16'h0, 16'hAAAA, 1, 3);    // R9 finishing edge
    run_txn(2'b00, 5'h09, 5'h0B, 16'h4444, 16'h0, 1, 2);    // R10 mid-frame
    run_txn(2'b01, 5'h09, 5'h0B, 16'h0, 16'h5555, 1, 0);    // R10 old settings kept

    for (int i = 0; i < 40; i++) begin
      set_cfg(bit'($urandom % 2), bit'($urandom % 2), int'($urandom % 4));
      run_txn(2'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
              16'($urandom), bit'(($urandom % 8) != 0), 0);
    end

    summary();
    $finish;
  end

endmodule